// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 32-bit virtual address into a physical address for a small processor that uses one level of paging. A requester hands over a virtual address with a valid/ready handshake. The unit splits the address into a 20-bit page index and a 12-bit byte offset. It then either lets the address straight through or looks up one page table entry in memory.

Three control registers set the behaviour. A translate-enable flag turns translation on or off. A table base gives the word address where the page table starts. A table size gives the number of entries. The table is read through a plain memory read port with one cycle of latency. Each request ends in a response that carries either a physical address or a fault flag. The response stays on the outputs until the requester accepts it.

The control registers are loaded through a separate write port. The unit accepts a new request, and changes its control registers, only while it is idle.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `tbl_rd_en` are 0, and the translate-enable flag, the table base and the table size are all 0.
- R2: With the translate-enable flag at 0, a request completes with `rsp_paddr` equal to `req_vaddr` and `rsp_fault` 0. No table read is issued.
- R3: With the flag at 1 and the page index (`req_vaddr[31:12]`) below the table size, exactly one table read is issued. Its word address is the table base plus the page index, modulo 2^32.
- R4: A fetched entry with bit 11 set gives `rsp_paddr` = {entry[31:12], `req_vaddr[11:0]`} with `rsp_fault` 0.
- R5: A fetched entry with bit 11 clear gives `rsp_fault` 1 with `rsp_paddr` 0.
- R6: With the flag at 1 and the page index greater than or equal to the table size, the response is a fault with `rsp_paddr` 0, and no table read is issued.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values.
- R8: `cfg_sel` selects the register that a `cfg_we` write loads. Value 0 loads the flag from `cfg_wdata[0]`. Value 1 loads the table base from all 32 bits. Value 2 loads the table size from `cfg_wdata[20:0]`. A write made while a request is in progress has no effect.
- R9: `req_ready` is 1 only while no request is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 2 | Register select: 0 flag, 1 base, 2 size |
| cfg_wdata | input | 32 | Control register write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Page fault |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_addr | output | 32 | Table read word address |
| tbl_rd_data | input | 32 | Table read data, valid the cycle after the strobe |

## Verification
Random addresses are tested against random table bases and sizes, with the page index held close to the size limit. This separates an in-range lookup from an out-of-range fault, and a valid entry from an invalid one. Table bases close to the top of the address space show whether the lookup address wraps. Passthrough requests show that disabling translation gives the address back unchanged and issues no read. Directed cases cover an empty table, the last legal index, the first illegal index, and control writes made during a lookup or while a response waits to be accepted. In the last two cases a stale or a changed register value would give a different read address or response.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_ORIGIN = 2'd1,
        SEL_LENGTH = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/pxu_cfg_regs.sv
module pxu_cfg_regs #(
    parameter int AW    = 32,
    parameter int LEN_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             busy,
    output logic             mode_q,
    output logic [AW-1:0]    origin_q,
    output logic [LEN_W-1:0] length_q
);
    import pxu_pkg::*;

    typedef struct packed {
        logic             mode;
        logic [AW-1:0]    origin;
        logic [LEN_W-1:0] length;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ok;

    assign wr_ok = cfg_we && !busy;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ok) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_MODE:   cfg_d.mode   = cfg_wdata[0];
                SEL_ORIGIN: cfg_d.origin = cfg_wdata;
                SEL_LENGTH: cfg_d.length = cfg_wdata[LEN_W-1:0];
                default:    cfg_d        = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode_q   = cfg_q.mode;
    assign origin_q = cfg_q.origin;
    assign length_q = cfg_q.length;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/pxu_pte_decode.sv
module pxu_pte_decode #(
    parameter int AW   = 32,
    parameter int BX_W = 12
) (
    input  logic [AW-1:0]   entry,
    input  logic [BX_W-1:0] bx,
    output logic            hit,
    output logic [AW-1:0]   paddr
);
    localparam int V_BIT = BX_W - 1;

    logic unused_low;

    assign hit        = entry[V_BIT];
    assign paddr      = {entry[AW-1:BX_W], bx};
    assign unused_low = ^entry[V_BIT-1:0];

endmodule

// File: rtl/pxu_walk_fsm.sv
module pxu_walk_fsm #(
    parameter int AW    = 32,
    parameter int BX_W  = 12,
    parameter int LEN_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic [AW-1:0]    origin,
    input  logic [LEN_W-1:0] length,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_vaddr,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [AW-1:0]    rsp_paddr,
    output logic             rsp_fault,
    output logic             tbl_rd_en,
    output logic [AW-1:0]    tbl_rd_addr,
    output logic [BX_W-1:0]  bx_q,
    input  logic             pte_hit,
    input  logic [AW-1:0]    pte_paddr,
    output logic             busy
);
    import pxu_pkg::*;

    localparam int PX_W = AW - BX_W;

    typedef struct packed {
        walk_state_e     st;
        logic [BX_W-1:0] bx;
        logic [AW-1:0]   rd_addr;
        logic [AW-1:0]   paddr;
        logic            fault;
    } walk_t;

    walk_t w_d, w_q;
    logic [PX_W-1:0] px;
    logic            px_oob;

    assign px     = req_vaddr[AW-1:BX_W];
    assign px_oob = LEN_W'(px) >= length;

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.bx = req_vaddr[BX_W-1:0];
                    if (!mode) begin
                        w_d.paddr = req_vaddr;
                        w_d.fault = 1'b0;
                        w_d.st    = ST_DONE;
                    end else if (px_oob) begin
                        w_d.paddr = '0;
                        w_d.fault = 1'b1;
                        w_d.st    = ST_DONE;
                    end else begin
                        w_d.rd_addr = origin + AW'(px);
                        w_d.st      = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: w_d.st = ST_WAIT;
            ST_WAIT: begin
                w_d.paddr = pte_hit ? pte_paddr : '0;
                w_d.fault = !pte_hit;
                w_d.st    = ST_DONE;
            end
            ST_DONE: if (rsp_ready) w_d.st = ST_IDLE;
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign req_ready   = (w_q.st == ST_IDLE);
    assign busy        = (w_q.st != ST_IDLE);
    assign tbl_rd_en   = (w_q.st == ST_ISSUE);
    assign tbl_rd_addr = w_q.rd_addr;
    assign rsp_valid   = (w_q.st == ST_DONE);
    assign rsp_paddr   = w_q.paddr;
    assign rsp_fault   = w_q.fault;
    assign bx_q        = w_q.bx;

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R7
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid && !tbl_rd_en); // R9
    AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |-> $past(req_valid && req_ready && mode)); // R3
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0); // R5

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
    parameter int AW   = 32,
    parameter int BX_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_paddr,
    output logic          rsp_fault,
    output logic          tbl_rd_en,
    output logic [AW-1:0] tbl_rd_addr,
    input  logic [AW-1:0] tbl_rd_data
);
    localparam int PX_W  = AW - BX_W;
    localparam int LEN_W = PX_W + 1;

    logic             mode_q;
    logic [AW-1:0]    origin_q;
    logic [LEN_W-1:0] length_q;
    logic             busy;
    logic [BX_W-1:0]  bx_q;
    logic             pte_hit;
    logic [AW-1:0]    pte_paddr;

    pxu_cfg_regs #(.AW(AW), .LEN_W(LEN_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .busy     (busy),
        .mode_q   (mode_q),
        .origin_q (origin_q),
        .length_q (length_q)
    );

    pxu_pte_decode #(.AW(AW), .BX_W(BX_W)) u_dec (
        .entry(tbl_rd_data),
        .bx   (bx_q),
        .hit  (pte_hit),
        .paddr(pte_paddr)
    );

    pxu_walk_fsm #(.AW(AW), .BX_W(BX_W), .LEN_W(LEN_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .origin     (origin_q),
        .length     (length_q),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .tbl_rd_en  (tbl_rd_en),
        .tbl_rd_addr(tbl_rd_addr),
        .bx_q       (bx_q),
        .pte_hit    (pte_hit),
        .pte_paddr  (pte_paddr),
        .busy       (busy)
    );

    AST_BYPASS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !mode_q |=> !tbl_rd_en); // R2
    AST_OOB_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && mode_q && (LEN_W'(req_vaddr[AW-1:BX_W]) >= length_q)
        |=> !tbl_rd_en && rsp_valid && rsp_fault); // R6

endmodule

// File: tb/page_xlate_unit_tb.sv
module page_xlate_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [31:0] req_vaddr = 0;
    logic        rsp_valid;
    logic        rsp_ready = 0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        tbl_rd_en;
    logic [31:0] tbl_rd_addr;
    logic [31:0] tbl_rd_data = 0;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    logic [31:0] last_raddr = 0;
    bit finished = 0;

    bit          sh_mode = 0;
    logic [31:0] sh_org = 0;
    logic [20:0] sh_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data)
    );

    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic [31:0] x;
        x = (a * 32'h9E3779B1) ^ (a << 7) ^ 32'h5A5A0C33;
        return x;
    endfunction

    always @(posedge clk) begin
        if (tbl_rd_en) begin
            tbl_rd_data <= pte_of(tbl_rd_addr);
            rd_count    <= rd_count + 1;
            last_raddr  <= tbl_rd_addr;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void model(input bit m, input logic [31:0] org, input logic [20:0] len,
                                  input logic [31:0] va, output logic [31:0] pa, output bit f,
                                  output int nrd, output logic [31:0] ra);
        logic [31:0] e;
        ra = org + {12'b0, va[31:12]};
        if (!m) begin
            pa = va; f = 0; nrd = 0;
        end else if ({1'b0, va[31:12]} >= len) begin
            pa = 0; f = 1; nrd = 0;
        end else begin
            e = pte_of(ra); nrd = 1;
            if (e[11]) begin pa = {e[31:12], va[11:0]}; f = 0; end
            else       begin pa = 0; f = 1; end
        end
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 0;
        case (sel)
            2'd0: sh_mode = data[0];
            2'd1: sh_org  = data;
            2'd2: sh_len  = data[20:0];
            default: ;
        endcase
    endtask

    task automatic start_req(input logic [31:0] va);
        @(negedge clk);
        chk("R9 ready before accept", req_ready, 1);
        req_valid = 1; req_vaddr = va;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_req(input int base_rd, output logic [31:0] pa, output bit f,
                              output int nrd);
        int t = 0;
        bit rdy_bad = 0;
        while (!rsp_valid && t < 20) begin
            if (req_ready) rdy_bad = 1;
            @(negedge clk);
            t++;
        end
        chk("R9 ready low while busy", rdy_bad, 0);
        chk("R7 response arrives", rsp_valid, 1);
        pa = rsp_paddr; f = rsp_fault;
        chk("R9 ready low with response", req_ready, 0);
        @(negedge clk);
        chk("R7 valid held", rsp_valid, 1);
        chk("R7 paddr held", rsp_paddr, pa);
        chk("R7 fault held", rsp_fault, f);
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk("R9 idle after ack", {req_ready, rsp_valid}, 2'b10);
        nrd = rd_count - base_rd;
    endtask

    task automatic run_check(input string tag, input logic [31:0] va);
        logic [31:0] pa, epa, era;
        bit f, ef;
        int nrd, enrd, base;
        model(sh_mode, sh_org, sh_len, va, epa, ef, enrd, era);
        base = rd_count;
        start_req(va);
        finish_req(base, pa, f, nrd);
        chk({tag, " paddr"}, pa, epa);
        chk({tag, " fault"}, f, ef);
        chk({tag, " reads"}, nrd, enrd);
        if (enrd == 1) chk({tag, " R3 read addr"}, last_raddr, era);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] va, pa;
        bit f;
        int nrd, base, px_v, px_nv;
        int seed;
        seed = 32'h1234;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        chk("R1 reset ready", req_ready, 1);
        chk("R1 reset rsp_valid", rsp_valid, 0);
        chk("R1 reset rd_en", tbl_rd_en, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", {req_ready, rsp_valid, tbl_rd_en}, 3'b100);

        // R1/R2: flag resets to 0, so translation is bypassed
        run_check("R1 R2 bypass after reset", 32'hDEADBEEF);
        run_check("R2 bypass", 32'h00000FFF);

        // R6: empty table
        cfg_write(2'd0, 32'h1);
        run_check("R6 empty table", 32'h00000123);

        cfg_write(2'd1, 32'h0000_4000);
        cfg_write(2'd2, 32'd16);
        run_check("R3 last legal index", {20'd15, 12'hABC});
        run_check("R6 first illegal index", {20'd16, 12'hABC});
        run_check("R6 max index", 32'hFFFFFFFF);

        // R4/R5: find entries with bit 11 set and clear
        px_v = -1; px_nv = -1;
        for (int i = 0; i < 16; i++) begin
            if (pte_of(32'h4000 + i) & 32'h800) begin if (px_v < 0) px_v = i; end
            else if (px_nv < 0) px_nv = i;
        end
        if (px_v >= 0)  run_check("R4 valid entry", {px_v[19:0], 12'h5A5});
        if (px_nv >= 0) run_check("R5 invalid entry", {px_nv[19:0], 12'h5A5});

        // R3 wrap of base + index
        cfg_write(2'd1, 32'hFFFF_FFF8);
        run_check("R3 wrapped read addr", {20'd12, 12'h001});

        // R8: write during lookup is ignored
        base = rd_count;
        start_req({20'd3, 12'h010});
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'd1; cfg_wdata = 32'h0000_8000;
        @(negedge clk);
        cfg_we = 0;
        finish_req(base, pa, f, nrd);
        run_check("R8 base unchanged after busy write", {20'd3, 12'h010});
        // R8: write while response is held is ignored
        start_req({20'd4, 12'h020});
        while (!rsp_valid) @(negedge clk);
        cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_we = 0; rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        run_check("R8 flag unchanged after busy write", {20'd5, 12'h030});

        // random mix
        for (int it = 0; it < 400; it++) begin
            if (it % 8 == 0) begin
                cfg_write(2'd0, ($urandom % 4 != 0) ? 32'h1 : 32'h0);
                cfg_write(2'd1, ($urandom % 3 == 0) ? (32'hFFFFFFFF - ($urandom % 40)) : $urandom);
                cfg_write(2'd2, $urandom % 41);
            end
            va = $urandom;
            if ($urandom % 4 != 0) va[31:12] = 20'($urandom % 48);
            run_check("R2 R3 R4 R5 R6 random", va);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule